// File: doc/BRIEF.md
# Omega Multistage Self-Routing Network

This block connects N input lines to N output lines through log2(N) pipelined stages of two-by-two switch elements, with N/2 elements per stage and a perfect-shuffle wiring pattern in front of every stage. Each input line offers, in any cycle, one packet made of a valid bit, a destination port number and a payload. The switches route themselves from the destination bits, with no central controller. Because exactly one path joins each input to each output, the network is blocking: two packets that reach the same switch and want the same output cannot both pass.

When such a contention occurs, the packet on the upper input of that switch wins and the other is discarded. The block reports the loss on a per-input blocked vector that is indexed by the line the lost packet entered on. A fresh set of up to N packets may be presented every clock. Each set leaves the network, as delivered payloads plus blocked flags, after log2(N) clock edges. There is no buffering and no retry. A user that needs guaranteed delivery resubmits the packets whose blocked flags were raised.

Top module: `omega_router`

## Requirements
- R1: While rst_ni is low and after reset, out_valid_o, out_data_o and blocked_o are all zero until a packet has had time to arrive.
- R2: A packet set sampled at a rising edge appears on the outputs right after the log2(N)-th rising edge, counting the sampling edge as the first. One set takes 3 edges with N=8.
- R3: An unblocked packet presents its payload on out_data_o slice d with out_valid_o bit d high, where d is its destination; out_valid_o bit j is never high for a packet whose destination differs from j.
- R4: In front of each stage, line i is wired to stage lane rotl(i), its log2(N)-bit index rotated left by one. For example, line 4 goes to lane 1. Lanes 2j and 2j+1 feed switch j, with lane 2j as the upper input.
- R5: Stage k, counting from 0, examines destination bit log2(N)-1-k, so the most significant bit is used first. A 0 sends the packet to the upper output (even lane) and a 1 sends it to the lower output (odd lane).
- R6: When both inputs of a switch carry valid packets that want the same output, the upper-input packet passes. The lower one is dropped, and blocked_o bit s goes high for exactly the one cycle in which its set emerges, where s is the input line it entered on.
- R7: An input whose in_valid_i bit is low produces no output, causes no contention and never raises a blocked flag.
- R8: A new packet set may be presented on every clock, and consecutive sets do not affect one another.
- R9: Only the straight and exchange settings are used. Every valid packet is either delivered on exactly one port or flagged blocked, never both and never duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | N_PORTS | Packet present on each input line |
| in_dest_i | input | N_PORTS*ADDR_W | Destination port per line, line i in bits [i*ADDR_W +: ADDR_W] |
| in_data_i | input | N_PORTS*DATA_W | Payload per line, line i in bits [i*DATA_W +: DATA_W] |
| out_valid_o | output | N_PORTS | Delivered packet present on each output port |
| out_data_o | output | N_PORTS*DATA_W | Delivered payload per output port |
| blocked_o | output | N_PORTS | Packet from input line i was dropped by contention |

## Verification
The bench builds the network with 8 ports and 8-bit payloads. This gives three stages, so conflicts can occur at the first, middle and last stage, and the shuffle wiring decides which pairs meet. The bench runs the full sweep of single packets from every input to every destination, all eight shift permutations, crafted pairs that do or do not share a switch, and long runs of random destinations under random and full valid masks. It compares each clock against a behavioural path-tracing model. With a back-to-back flow of sets, any latency slip or cross-set leakage shows up on the next compare.

// File: rtl/omega_pkg.sv
package omega_pkg;

  typedef enum logic [1:0] {
    SW_STRAIGHT = 2'd0,
    SW_EXCHANGE = 2'd1,
    SW_BCAST_UP = 2'd2,
    SW_BCAST_DN = 2'd3
  } sw_set_e;

  // perfect shuffle: rotate a bits-wide index left by one
  function automatic int unsigned shuffle_idx(int unsigned idx, int unsigned bits);
    int unsigned mask;
    mask = (32'd1 << bits) - 32'd1;
    return ((idx << 1) | (idx >> (bits - 1))) & mask;
  endfunction

endpackage

// File: rtl/omega_shuffle.sv
module omega_shuffle #(
  parameter int unsigned N_LANES = 8,
  parameter int unsigned LANE_W  = 8,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [N_LANES-1:0][LANE_W-1:0] lane_i,
  output logic [N_LANES-1:0][LANE_W-1:0] lane_o
);

  for (genvar i = 0; i < N_LANES; i++) begin : g_wire
    localparam int unsigned DST = omega_pkg::shuffle_idx(i, IDX_W);
    assign lane_o[DST] = lane_i[i];
  end

endmodule

// File: rtl/omega_switch.sv
module omega_switch (
  input  logic               hi_v_i,
  input  logic               hi_bit_i,
  input  logic               lo_v_i,
  input  logic               lo_bit_i,
  output omega_pkg::sw_set_e set_o,
  output logic               up_v_o,
  output logic               dn_v_o,
  output logic               drop_lo_o
);

  logic conflict;
  logic exch;

  assign conflict = hi_v_i & lo_v_i & (hi_bit_i == lo_bit_i);
  // upper packet steers the element; otherwise the lower one does
  assign exch     = hi_v_i ? hi_bit_i : (lo_v_i & ~lo_bit_i);

  assign set_o     = exch ? omega_pkg::SW_EXCHANGE : omega_pkg::SW_STRAIGHT;
  assign up_v_o    = exch ? (lo_v_i & ~conflict) : hi_v_i;
  assign dn_v_o    = exch ? hi_v_i : (lo_v_i & ~conflict);
  assign drop_lo_o = conflict;

endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int unsigned N_LANES   = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned STAGE_IDX = 0
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [N_LANES-1:0]                 v_i,
  input  logic [N_LANES-1:0][ADDR_W-1:0]     dst_i,
  input  logic [N_LANES-1:0][ADDR_W-1:0]     src_i,
  input  logic [N_LANES-1:0][DATA_W-1:0]     dat_i,
  input  logic [N_LANES-1:0]                 blk_i,
  output logic [N_LANES-1:0]                 v_o,
  output logic [N_LANES-1:0][ADDR_W-1:0]     dst_o,
  output logic [N_LANES-1:0][ADDR_W-1:0]     src_o,
  output logic [N_LANES-1:0][DATA_W-1:0]     dat_o,
  output logic [N_LANES-1:0]                 blk_o
);

  localparam int unsigned LANE_W = 1 + 2 * ADDR_W + DATA_W;
  localparam int unsigned N_SW   = N_LANES / 2;
  localparam int unsigned BIT    = ADDR_W - 1 - STAGE_IDX;

  logic [N_LANES-1:0][LANE_W-1:0] lane_in, lane_sh;
  logic [N_LANES-1:0]             sh_v, nx_v;
  logic [N_LANES-1:0][ADDR_W-1:0] sh_dst, sh_src, nx_dst, nx_src;
  logic [N_LANES-1:0][DATA_W-1:0] sh_dat, nx_dat;
  logic [N_SW-1:0]                drop;
  logic [N_LANES-1:0]             blk_nx;
  omega_pkg::sw_set_e             sw_set [N_SW];

  always_comb begin
    for (int i = 0; i < N_LANES; i++) begin
      lane_in[i] = {v_i[i], dst_i[i], src_i[i], dat_i[i]};
      {sh_v[i], sh_dst[i], sh_src[i], sh_dat[i]} = lane_sh[i];
    end
  end

  omega_shuffle #(
    .N_LANES(N_LANES),
    .LANE_W (LANE_W),
    .IDX_W  (ADDR_W)
  ) u_shuffle (
    .lane_i(lane_in),
    .lane_o(lane_sh)
  );

  for (genvar j = 0; j < N_SW; j++) begin : g_sw
    omega_switch u_sw (
      .hi_v_i   (sh_v[2*j]),
      .hi_bit_i (sh_dst[2*j][BIT]),
      .lo_v_i   (sh_v[2*j+1]),
      .lo_bit_i (sh_dst[2*j+1][BIT]),
      .set_o    (sw_set[j]),
      .up_v_o   (nx_v[2*j]),
      .dn_v_o   (nx_v[2*j+1]),
      .drop_lo_o(drop[j])
    );

    // R9: every valid input leaves as one valid output or one drop
    p_switch_count_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($countones({nx_v[2*j], nx_v[2*j+1]}) + 32'(drop[j]))
        == $countones({sh_v[2*j], sh_v[2*j+1]}));
  end

  always_comb begin
    blk_nx = blk_i;
    for (int j = 0; j < N_SW; j++) begin
      if (sw_set[j] == omega_pkg::SW_EXCHANGE) begin
        nx_dst[2*j]   = sh_dst[2*j+1];
        nx_src[2*j]   = sh_src[2*j+1];
        nx_dat[2*j]   = sh_dat[2*j+1];
        nx_dst[2*j+1] = sh_dst[2*j];
        nx_src[2*j+1] = sh_src[2*j];
        nx_dat[2*j+1] = sh_dat[2*j];
      end else begin
        nx_dst[2*j]   = sh_dst[2*j];
        nx_src[2*j]   = sh_src[2*j];
        nx_dat[2*j]   = sh_dat[2*j];
        nx_dst[2*j+1] = sh_dst[2*j+1];
        nx_src[2*j+1] = sh_src[2*j+1];
        nx_dat[2*j+1] = sh_dat[2*j+1];
      end
      if (drop[j]) blk_nx[sh_src[2*j+1]] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_o   <= '0;
      dst_o <= '0;
      src_o <= '0;
      dat_o <= '0;
      blk_o <= '0;
    end else begin
      v_o   <= nx_v;
      dst_o <= nx_dst;
      src_o <= nx_src;
      dat_o <= nx_dat;
      blk_o <= blk_nx;
    end
  end

  for (genvar l = 0; l < N_LANES; l++) begin : g_chk
    // R5: a packet on an even lane had bit BIT clear, odd lane set
    p_route_bit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      v_o[l] |-> (dst_o[l][BIT] == 1'(l % 2)));
  end

  // R6: registered packets plus blocked flags equal what entered the stage
  p_conserve_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ($countones(v_o) + $countones(blk_o))
             == $past($countones(v_i) + $countones(blk_i)));

endmodule

// File: rtl/omega_router.sv
module omega_router #(
  parameter int unsigned N_PORTS = 8,
  parameter int unsigned DATA_W  = 8,
  localparam int unsigned ADDR_W = $clog2(N_PORTS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [N_PORTS-1:0]           in_valid_i,
  input  logic [N_PORTS*ADDR_W-1:0]    in_dest_i,
  input  logic [N_PORTS*DATA_W-1:0]    in_data_i,
  output logic [N_PORTS-1:0]           out_valid_o,
  output logic [N_PORTS*DATA_W-1:0]    out_data_o,
  output logic [N_PORTS-1:0]           blocked_o
);

  localparam int unsigned STAGES = ADDR_W;

  logic [STAGES:0][N_PORTS-1:0]             st_v;
  logic [STAGES:0][N_PORTS-1:0][ADDR_W-1:0] st_dst;
  logic [STAGES:0][N_PORTS-1:0][ADDR_W-1:0] st_src;
  logic [STAGES:0][N_PORTS-1:0][DATA_W-1:0] st_dat;
  logic [STAGES:0][N_PORTS-1:0]             st_blk;

  assign st_v[0]   = in_valid_i;
  assign st_dst[0] = in_dest_i;
  assign st_dat[0] = in_data_i;
  assign st_blk[0] = '0;

  for (genvar i = 0; i < N_PORTS; i++) begin : g_tag
    assign st_src[0][i] = ADDR_W'(i);
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    omega_stage #(
      .N_LANES  (N_PORTS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .STAGE_IDX(s)
    ) u_stage (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .v_i   (st_v[s]),
      .dst_i (st_dst[s]),
      .src_i (st_src[s]),
      .dat_i (st_dat[s]),
      .blk_i (st_blk[s]),
      .v_o   (st_v[s+1]),
      .dst_o (st_dst[s+1]),
      .src_o (st_src[s+1]),
      .dat_o (st_dat[s+1]),
      .blk_o (st_blk[s+1])
    );
  end

  assign out_valid_o = st_v[STAGES];
  assign out_data_o  = st_dat[STAGES];
  assign blocked_o   = st_blk[STAGES];

  for (genvar j = 0; j < N_PORTS; j++) begin : g_out_chk
    // R3: a delivered packet carries the destination of its port
    p_dest_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      out_valid_o[j] |-> (st_dst[STAGES][j] == ADDR_W'(j)));
  end

endmodule

// File: tb/sim_omega_router.sv
`timescale 1ns/1ps
module sim_omega_router;

  localparam int N = 8;
  localparam int D = 8;
  localparam int A = $clog2(N);
  localparam int S = A;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [N-1:0]     in_v = '0;
  logic [N*A-1:0]   in_dst = '0;
  logic [N*D-1:0]   in_dat = '0;
  logic [N-1:0]     out_v;
  logic [N*D-1:0]   out_dat;
  logic [N-1:0]     blk;

  int    n_chk = 0;
  int    n_bad = 0;
  string tag   = "R1";

  logic [N-1:0]   q_v[$];
  logic [N-1:0]   q_b[$];
  logic [N*D-1:0] q_d[$];

  always #2.5 clk = ~clk;

  omega_router #(.N_PORTS(N), .DATA_W(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_v), .in_dest_i(in_dst), .in_data_i(in_dat),
    .out_valid_o(out_v), .out_data_o(out_dat), .blocked_o(blk)
  );

  function automatic int rotl(int x);
    return ((x << 1) | (x >> (A - 1))) & (N - 1);
  endfunction

  // path-tracing model of one packet set
  task automatic model(input logic [N-1:0] v, input logic [N*A-1:0] dv,
                       input logic [N*D-1:0] pv, output logic [N-1:0] ev,
                       output logic [N*D-1:0] ed, output logic [N-1:0] eb);
    int pos[N];
    bit alive[N];
    bit lose[N];
    ev = '0; ed = '0; eb = '0;
    for (int i = 0; i < N; i++) begin pos[i] = i; alive[i] = v[i]; end
    for (int k = 0; k < S; k++) begin
      for (int i = 0; i < N; i++) begin
        lose[i] = 1'b0;
        if (alive[i]) pos[i] = rotl(pos[i]);
      end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (i != j && alive[i] && alive[j] && (pos[i] >> 1) == (pos[j] >> 1)
              && dv[i*A + A-1-k] == dv[j*A + A-1-k] && pos[i][0])
            lose[i] = 1'b1;
      for (int i = 0; i < N; i++) begin
        if (lose[i]) begin alive[i] = 1'b0; eb[i] = 1'b1; end
        else if (alive[i]) pos[i] = (pos[i] & ~1) | int'(dv[i*A + A-1-k]);
      end
    end
    for (int i = 0; i < N; i++)
      if (alive[i]) begin
        ev[pos[i]] = 1'b1;
        ed[pos[i]*D +: D] = pv[i*D +: D];
      end
  endtask

  task automatic check(input string r, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [N-1:0] ev, eb;
    logic [N*D-1:0] ed;
    ev = q_v.pop_front(); eb = q_b.pop_front(); ed = q_d.pop_front();
    check(tag, "out_valid", longint'(out_v), longint'(ev));
    check(tag, "blocked", longint'(blk), longint'(eb));
    for (int p = 0; p < N; p++)
      if (ev[p]) check(tag, $sformatf("data port %0d", p),
                       longint'(out_dat[p*D +: D]), longint'(ed[p*D +: D]));
  endtask

  task automatic step(input logic [N-1:0] v, input logic [N*A-1:0] dv,
                      input logic [N*D-1:0] pv);
    logic [N-1:0] ev, eb;
    logic [N*D-1:0] ed;
    @(negedge clk);
    compare();
    in_v = v; in_dst = dv; in_dat = pv;
    model(v, dv, pv, ev, ed, eb);
    q_v.push_back(ev); q_b.push_back(eb); q_d.push_back(ed);
  endtask

  function automatic logic [N*D-1:0] rnd_data();
    logic [N*D-1:0] r;
    for (int i = 0; i < N; i++) r[i*D +: D] = D'($urandom);
    return r;
  endfunction

  function automatic logic [N*A-1:0] rnd_dst();
    logic [N*A-1:0] r;
    for (int i = 0; i < N; i++) r[i*A +: A] = A'($urandom);
    return r;
  endfunction

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) step('0, '0, '0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [N*A-1:0] dv;
    logic [N*D-1:0] pv;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", longint'(out_v), 0);
    check("R1", "out_data in reset", longint'(out_dat), 0);
    check("R1", "blocked in reset", longint'(blk), 0);
    rst_n = 1'b1;
    for (int c = 0; c < S; c++) begin
      q_v.push_back('0); q_b.push_back('0); q_d.push_back('0);
    end
    tag = "R1";
    idle(S);

    // R2: lone packet line 0 -> port 5, latency S edges
    tag = "R2";
    dv = '0; dv[0 +: A] = A'(5);
    pv = '0; pv[0 +: D] = 8'hA5;
    step(8'h01, dv, pv);
    idle(S + 1);

    // R3: all shift permutations pass unblocked
    tag = "R3";
    for (int sh = 0; sh < N; sh++) begin
      for (int i = 0; i < N; i++) dv[i*A +: A] = A'((i + sh) % N);
      step('1, dv, rnd_data());
    end
    idle(S);

    // R4: lines 0 and 4 share switch 0 of stage 0; lines 0 and 1 do not
    tag = "R4";
    dv = '0; dv[0*A +: A] = A'(0); dv[4*A +: A] = A'(1);
    step(8'h11, dv, rnd_data());
    dv = '0; dv[0*A +: A] = A'(0); dv[1*A +: A] = A'(1);
    step(8'h03, dv, rnd_data());
    dv = '0; dv[1*A +: A] = A'(2); dv[5*A +: A] = A'(3);
    step(8'h22, dv, rnd_data());
    idle(S);

    // R5: single packets with MSB 1 vs 0 from one line
    tag = "R5";
    for (int d = 0; d < N; d++) begin
      dv = '0; dv[6*A +: A] = A'(d);
      step(8'h40, dv, rnd_data());
      idle(1);
    end
    idle(S);

    // R6: contention, including all lines to one port
    tag = "R6";
    dv = '0; step('1, dv, rnd_data());
    for (int i = 0; i < N; i++) dv[i*A +: A] = A'(N - 1);
    step('1, dv, rnd_data());
    for (int i = 0; i < N; i++) dv[i*A +: A] = A'(((i & 1) << (A-1)) | (i >> 1));
    step('1, dv, rnd_data());
    for (int c = 0; c < 150; c++) step('1, rnd_dst(), rnd_data());
    idle(S);

    // R7: random valid masks
    tag = "R7";
    for (int c = 0; c < 200; c++) step(N'($urandom), rnd_dst(), rnd_data());
    idle(S);

    // R8: back-to-back sweep of every line to every port
    tag = "R8";
    for (int i = 0; i < N; i++)
      for (int d = 0; d < N; d++) begin
        dv = '0; dv[i*A +: A] = A'(d);
        step(N'(1) << i, dv, rnd_data());
      end
    idle(S);

    // R9: heavy hot-spot traffic, one delivery or one flag per packet
    tag = "R9";
    for (int c = 0; c < 40; c++) begin
      for (int i = 0; i < N; i++) dv[i*A +: A] = A'(($urandom % 2) ? 0 : 7);
      step(N'($urandom) | 8'h81, dv, rnd_data());
    end
    idle(S + 1);

    finish_run();
  end

endmodule